// File: doc/BRIEF.md
# Password retry lockout controller

This block decides whether a host may use a protected storage device. The host first gives a command: read, write, reset device or reset password. It then presents a 64-bit password as eight byte strobes. The block compares each byte as it arrives against the stored password that the command selects. After the last byte it always waits for a modelled nonvolatile write cycle to end, which it sees as a done pulse. Only then does it reveal the result, as an ACK or NACK answer to a polling probe and as an access-granted level. The host cannot tell a wrong password from a busy device until the write cycle is over.

Every failed attempt adds one to a retry counter, whatever the command. Eight failures are tolerated, and the ninth locks the device. When the device locks, the block raises a one-cycle request to clear all storage and refuses every later read and write match. The stored passwords are not changed. Only a reset-device command that carries the reset password unlocks the device. A reset-password command that matches requests a clear of the storage and sets all three passwords to zero. The passwords live in registers inside the block, and the block has no path to read them out.

The controller is a four-state machine:
- IDLE waits for the first command.
- COLLECT takes the eight password bytes.
- WRITE waits for the write-cycle done pulse.
- REPORT holds the verdict until the next command.

The transitions are:
- start: IDLE to COLLECT on a command strobe.
- eighth byte: COLLECT to WRITE.
- cycle end: WRITE to REPORT on the done pulse.
- restart: REPORT to COLLECT on a new command strobe.

Top module: `pwg_guard`

## Requirements
- R1: After reset the counter is zero and the lock flag is low. Eight consecutive failed attempts leave the lock low. The ninth failure sets the lock in the cycle after its last byte and pulses the clear request for exactly one cycle.
- R2: A wrong password counts as a failure under every command code: 00 read, 01 write, 10 reset device, 11 reset password.
- R3: While locked, read, write and reset-password commands fail even with the correct password. The counter is held, so further failures give no new clear request. The stored passwords are unchanged.
- R4: A correct password before overflow clears the counter. For read and write commands, access_grant is high in REPORT. It stays low in every other state and for the two reset commands.
- R5: A poll strobe is answered in the next cycle by poll_resp_valid high together with poll_ack. poll_ack is 1 only in REPORT after a matched password. It is 0 in IDLE, COLLECT and WRITE, and it stays 0 in REPORT after a wrong password.
- R6: A reset-device command with the correct reset password clears the lock and the counter, and leaves every password unchanged. Before overflow its only effect is to clear the counter.
- R7: A reset-password command with the correct reset password, while not locked, pulses clear_req and zeroise_req together for one cycle. It sets all three passwords to zero and clears the counter.
- R8: Reset loads the three passwords from parameters, which default to all zeros.
- R9: The first byte after a command is compared with bits 63:56 of the stored password and the eighth with bits 7:0. A difference in any single byte fails the attempt.
- R10: A command strobe in COLLECT or WRITE is ignored, and the attempt in progress completes with its own verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 00 read, 01 write, 10 reset device, 11 reset password |
| pw_valid | input | 1 | Password byte strobe |
| pw_byte | input | 8 | Password byte, most significant byte first |
| wc_done | input | 1 | End of the modelled nonvolatile write cycle |
| poll | input | 1 | Polling probe |
| poll_resp_valid | output | 1 | Answer to the probe is present |
| poll_ack | output | 1 | 1 = ACK, 0 = NACK |
| access_grant | output | 1 | Read or write access granted |
| lock | output | 1 | Device locked after counter overflow |
| clear_req | output | 1 | One-cycle request to clear all storage |
| zeroise_req | output | 1 | One-cycle request marking that the passwords were zeroed |

## Verification
The hardest condition to reach is the exact boundary of the retry counter. The counter cannot be read, so its value shows only when the lock sets on the ninth failure and not on the eighth. The bench sweeps every failure count from zero to eight, each followed by a correct password. It then mixes all four commands in a run of failures that ends in lock. It probes the locked state with correct passwords, including a case where the counter was cleared by a reset-device command before overflow. Wrong passwords differ from the stored one in a single rotating byte, which exercises the per-byte compare.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    typedef enum logic [1:0] {
        CMD_READ    = 2'b00,
        CMD_WRITE   = 2'b01,
        CMD_RST_DEV = 2'b10,
        CMD_RST_PW  = 2'b11
    } pwg_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_WRITE   = 2'd2,
        ST_REPORT  = 2'd3
    } pwg_state_e;

    localparam int unsigned NUM_PW = 3;
endpackage

// File: rtl/pwg_store.sv
module pwg_store
    import pwg_pkg::*;
#(
    parameter int unsigned    PW_W    = 64,
    parameter logic [PW_W-1:0] INIT_RD = '0,
    parameter logic [PW_W-1:0] INIT_WR = '0,
    parameter logic [PW_W-1:0] INIT_RS = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            zeroise,
    input  pwg_cmd_e        sel,
    output logic [PW_W-1:0] exp_pw
);
    logic [PW_W-1:0] pw_q [NUM_PW];

    for (genvar g = 0; g < NUM_PW; g++) begin : g_pw
        localparam logic [PW_W-1:0] INIT_V = (g == 0) ? INIT_RD :
                                             (g == 1) ? INIT_WR : INIT_RS;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pw_q[g] <= INIT_V;
            else if (zeroise) pw_q[g] <= '0;
        end
    end

    always_comb begin
        unique case (sel)
            CMD_READ:  exp_pw = pw_q[0];
            CMD_WRITE: exp_pw = pw_q[1];
            default:   exp_pw = pw_q[2];
        endcase
    end
endmodule

// File: rtl/pwg_cmp.sv
module pwg_cmp #(
    parameter int unsigned NBYTES = 8,
    localparam int unsigned PW_W  = NBYTES * 8,
    localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            byte_vld,
    input  logic [7:0]      byte_in,
    input  logic [PW_W-1:0] exp_pw,
    output logic            last_byte,
    output logic            match
);
    logic [IDX_W-1:0] idx_q;
    logic             miss_q;
    logic [7:0]       exp_byte;
    logic             byte_eq;

    assign exp_byte  = exp_pw[(NBYTES - 1 - int'(idx_q)) * 8 +: 8];
    assign byte_eq   = (exp_byte == byte_in);
    assign last_byte = byte_vld && (idx_q == IDX_W'(NBYTES - 1));
    assign match     = !miss_q && byte_eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            miss_q <= 1'b0;
        end else if (start) begin
            idx_q  <= '0;
            miss_q <= 1'b0;
        end else if (byte_vld) begin
            idx_q  <= last_byte ? '0 : idx_q + 1'b1;
            miss_q <= miss_q || !byte_eq;
        end
    end
endmodule

// File: rtl/pwg_retry.sv
module pwg_retry
    import pwg_pkg::*;
#(
    parameter int unsigned LIMIT = 8,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             pass,
    input  pwg_cmd_e         cmd,
    output logic             locked,
    output logic             ok,
    output logic             overflow,
    output logic [CNT_W-1:0] fail_cnt
);
    logic at_limit;

    assign at_limit = (fail_cnt == CNT_W'(LIMIT));
    assign ok       = pass && (!locked || cmd == CMD_RST_DEV);
    assign overflow = eval && !locked && !pass && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_cnt <= '0;
            locked   <= 1'b0;
        end else if (eval) begin
            if (locked) begin
                if (ok) begin
                    locked   <= 1'b0;
                    fail_cnt <= '0;
                end
            end else if (pass) begin
                fail_cnt <= '0;
            end else if (at_limit) begin
                locked <= 1'b1;
            end else begin
                fail_cnt <= fail_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwg_guard.sv
module pwg_guard
    import pwg_pkg::*;
#(
    parameter int unsigned NBYTES   = 8,
    parameter int unsigned TRY_MAX  = 8,
    parameter logic [NBYTES*8-1:0] PW_RD_INIT = '0,
    parameter logic [NBYTES*8-1:0] PW_WR_INIT = '0,
    parameter logic [NBYTES*8-1:0] PW_RS_INIT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       pw_valid,
    input  logic [7:0] pw_byte,
    input  logic       wc_done,
    input  logic       poll,
    output logic       poll_resp_valid,
    output logic       poll_ack,
    output logic       access_grant,
    output logic       lock,
    output logic       clear_req,
    output logic       zeroise_req
);
    localparam int unsigned PW_W  = NBYTES * 8;
    localparam int unsigned CNT_W = $clog2(TRY_MAX + 1);

    pwg_state_e       state_q, state_d;
    pwg_cmd_e         cmd_q;
    logic             ok_q;
    logic [PW_W-1:0]  exp_pw;
    logic             last_byte, match, start, eval;
    logic             ok, overflow, zero_now;
    logic [CNT_W-1:0] fail_cnt;

    assign start    = cmd_valid && (state_q == ST_IDLE || state_q == ST_REPORT);
    assign eval     = (state_q == ST_COLLECT) && last_byte;
    assign zero_now = eval && ok && (cmd_q == CMD_RST_PW);

    pwg_store #(
        .PW_W(PW_W), .INIT_RD(PW_RD_INIT), .INIT_WR(PW_WR_INIT), .INIT_RS(PW_RS_INIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .zeroise(zero_now), .sel(cmd_q), .exp_pw(exp_pw)
    );

    pwg_cmp #(.NBYTES(NBYTES)) u_cmp (
        .clk(clk), .rst_n(rst_n), .start(start),
        .byte_vld(pw_valid && state_q == ST_COLLECT), .byte_in(pw_byte),
        .exp_pw(exp_pw), .last_byte(last_byte), .match(match)
    );

    pwg_retry #(.LIMIT(TRY_MAX)) u_retry (
        .clk(clk), .rst_n(rst_n), .eval(eval), .pass(match), .cmd(cmd_q),
        .locked(lock), .ok(ok), .overflow(overflow), .fail_cnt(fail_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = ST_COLLECT;
            ST_COLLECT: if (last_byte) state_d = ST_WRITE;
            ST_WRITE:   if (wc_done)   state_d = ST_REPORT;
            ST_REPORT:  if (cmd_valid) state_d = ST_COLLECT;
        endcase
    end

    // state register with command and verdict capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_READ;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cmd_q <= pwg_cmd_e'(cmd_code);
                ok_q  <= 1'b0;
            end else if (eval) begin
                ok_q <= ok;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_resp_valid <= 1'b0;
            poll_ack        <= 1'b0;
            clear_req       <= 1'b0;
            zeroise_req     <= 1'b0;
        end else begin
            poll_resp_valid <= poll;
            poll_ack        <= poll && (state_q == ST_REPORT) && ok_q;
            clear_req       <= overflow || zero_now;
            zeroise_req     <= zero_now;
        end
    end

    assign access_grant = (state_q == ST_REPORT) && ok_q &&
                          (cmd_q == CMD_READ || cmd_q == CMD_WRITE);
endmodule

// File: rtl/pwg_guard_chk.sv
module pwg_guard_chk
    import pwg_pkg::*;
#(
    parameter int unsigned TRY_MAX = 8,
    parameter int unsigned CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             poll_resp_valid,
    input logic             poll_ack,
    input logic             access_grant,
    input logic             lock,
    input logic             clear_req,
    input logic             zeroise_req,
    input logic             wc_done,
    input pwg_state_e       state_q,
    input logic [CNT_W-1:0] fail_cnt
);
    // R1: counter never passes its limit
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fail_cnt <= CNT_W'(TRY_MAX));
    // R1: lock rises together with a clear request
    a_r1_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> clear_req);
    // R3: no grant while locked
    a_r3_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !access_grant);
    // R4: grant only in REPORT, entered through a done pulse
    a_r4_grant_state: assert property (@(posedge clk) disable iff (!rst_n)
        access_grant |-> state_q == ST_REPORT);
    a_r4_grant_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_grant) |-> $past(wc_done));
    // R5: ack only as a response
    a_r5_ack_is_resp: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> poll_resp_valid);
    // R6: unlock only happens while the counter is cleared
    a_r6_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> fail_cnt == '0);
    // R7: zeroise always comes with clear, and pulses for one cycle
    a_r7_zero_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        zeroise_req |-> clear_req);
    a_r7_zero_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        zeroise_req |=> !zeroise_req);
endmodule

bind pwg_guard pwg_guard_chk #(.TRY_MAX(TRY_MAX), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .poll_resp_valid(poll_resp_valid),
    .poll_ack(poll_ack), .access_grant(access_grant), .lock(lock),
    .clear_req(clear_req), .zeroise_req(zeroise_req), .wc_done(wc_done),
    .state_q(state_q), .fail_cnt(fail_cnt)
);

// File: tb/pwg_guard_bench.sv
module pwg_guard_bench;
    localparam logic [63:0] RD = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] WR = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] RS = 64'h5A5A_A5A5_3C3C_C3C3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, pw_valid = 0, wc_done = 0, poll = 0;
    logic [1:0] cmd_code = 0;
    logic [7:0] pw_byte = 0;
    logic poll_resp_valid, poll_ack, access_grant, lock, clear_req, zeroise_req;

    int checks = 0, errors = 0, clr_n = 0, zer_n = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwg_guard #(.PW_RD_INIT(RD), .PW_WR_INIT(WR), .PW_RS_INIT(RS)) u_pwg_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .pw_valid(pw_valid), .pw_byte(pw_byte), .wc_done(wc_done), .poll(poll),
        .poll_resp_valid(poll_resp_valid), .poll_ack(poll_ack),
        .access_grant(access_grant), .lock(lock), .clear_req(clear_req),
        .zeroise_req(zeroise_req)
    );

    always @(negedge clk) begin
        if (clear_req)   clr_n++;
        if (zeroise_req) zer_n++;
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_poll(output logic v, output logic a);
        poll = 1;
        @(negedge clk);
        poll = 0;
        v = poll_resp_valid;
        a = poll_ack;
    endtask

    // One full attempt; exp_ok is the verdict the requirements predict.
    task automatic attempt(input logic [1:0] c, input logic [63:0] pw,
                           input bit exp_ok, input string tag, input bit inject);
        logic v, a;
        @(negedge clk);
        cmd_valid = 1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 0;
        for (int i = 0; i < 8; i++) begin
            pw_valid = 1;
            pw_byte  = pw[63 - 8*i -: 8];
            if (inject && i == 3) begin cmd_valid = 1; cmd_code = 2'b11; end
            @(negedge clk);
            cmd_valid = 0;
        end
        pw_valid = 0;
        if (inject) begin cmd_valid = 1; cmd_code = 2'b00; @(negedge clk); cmd_valid = 0; end
        do_poll(v, a);
        chk(v, 1, {tag, " R5 busy resp"});
        chk(a, 0, {tag, " R5 busy nack"});
        chk(access_grant, 0, {tag, " R4 no grant busy"});
        wc_done = 1;
        @(negedge clk);
        wc_done = 0;
        do_poll(v, a);
        chk(a, exp_ok, {tag, " R5 poll verdict"});
        chk(access_grant, exp_ok && (c == 2'b00 || c == 2'b01), {tag, " R4 grant"});
    endtask

    function automatic logic [63:0] spoil(input logic [63:0] p, input int j);
        return p ^ (64'hFF << (8 * (j % 8)));
    endfunction

    initial begin
        int c0, z0;
        logic v, a;
        repeat (3) @(negedge clk);
        chk(lock, 0, "R1 reset lock");
        chk(access_grant, 0, "R8 reset grant");
        chk(clear_req, 0, "R8 reset clear");
        do_poll(v, a);
        chk(a, 0, "R5 idle nack");
        // R8/R9: loaded passwords, byte order
        attempt(2'b00, RD, 1, "R8 rd init", 0);
        attempt(2'b01, WR, 1, "R9 wr init", 0);
        attempt(2'b00, {RD[7:0], RD[63:8]}, 0, "R9 byte order", 0);
        attempt(2'b00, RD, 1, "R4 clear after fail", 0);
        // R1/R9 sweep: n failures then a correct one
        for (int n = 0; n <= 8; n++) begin
            for (int k = 0; k < n; k++)
                attempt(2'b00, spoil(RD, k + n), 0, "R9 single byte", 0);
            chk(lock, 0, "R1 no lock within limit");
            attempt(2'b01, WR, 1, "R4 correct resets count", 0);
        end
        // R2: mixed commands to overflow
        c0 = clr_n;
        for (int k = 0; k < 8; k++)
            attempt(2'(k % 4), spoil(k % 4 == 0 ? RD : k % 4 == 1 ? WR : RS, k), 0, "R2 mixed", 0);
        chk(lock, 0, "R2 eight mixed no lock");
        attempt(2'b11, spoil(RS, 2), 0, "R1 ninth", 0);
        chk(lock, 1, "R1 ninth locks");
        chk(clr_n - c0, 1, "R1 one clear pulse");
        chk(zer_n, 0, "R1 no zeroise");
        // R3: locked refuses correct passwords, no new clear
        attempt(2'b00, RD, 0, "R3 locked read", 0);
        attempt(2'b01, WR, 0, "R3 locked write", 0);
        attempt(2'b11, RS, 0, "R3 locked rstpw", 0);
        attempt(2'b10, spoil(RS, 5), 0, "R6 locked wrong rstdev", 0);
        chk(lock, 1, "R3 still locked");
        chk(clr_n - c0, 1, "R3 counter held");
        chk(zer_n, 0, "R3 no zeroise locked");
        attempt(2'b10, RS, 1, "R6 unlock", 0);
        chk(lock, 0, "R6 lock cleared");
        attempt(2'b00, RD, 1, "R6 pw unchanged", 0);
        // R6 before overflow only clears counter
        for (int k = 0; k < 5; k++) attempt(2'b01, spoil(WR, k), 0, "R6 pre", 0);
        attempt(2'b10, RS, 1, "R6 rstdev early", 0);
        chk(lock, 0, "R6 no lock change");
        for (int k = 0; k < 8; k++) attempt(2'b00, spoil(RD, k), 0, "R6 refill", 0);
        chk(lock, 0, "R6 counter was cleared");
        attempt(2'b00, RD, 1, "R6 pw still valid", 0);
        // R10: strobes inside COLLECT and WRITE ignored
        attempt(2'b01, WR, 1, "R10 ignored strobe", 1);
        chk(zer_n, 0, "R10 no zeroise from strobe");
        // R7: reset password
        c0 = clr_n; z0 = zer_n;
        attempt(2'b11, RS, 1, "R7 rstpw", 0);
        chk(clr_n - c0, 1, "R7 clear pulse");
        chk(zer_n - z0, 1, "R7 zeroise pulse");
        attempt(2'b00, RD, 0, "R7 old rd refused", 0);
        attempt(2'b00, 64'h0, 1, "R7 rd zero", 0);
        attempt(2'b01, 64'h0, 1, "R7 wr zero", 0);
        attempt(2'b10, 64'h0, 1, "R7 rs zero", 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #25 rst_n = 1'b1;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule